// File: doc/BRIEF.md
# Counted-Assertion Interrupt Delivery Engine

This block decides when each of a set of interrupt pins (24 by default) sends a delivery message toward the local interrupt controllers. Each pin has a stored routing entry. Each pin also keeps a running count of how many sources currently assert it, and a remote-IRR flag. Pin requests (assert, deassert, pulse), end-of-interrupt notices carrying an 8-bit vector, and entry writes all update this state. Each of these events can make a pin pending. Pending pins leave the block one at a time as messages over a valid/ready handshake.

A pin is triggered only when its count goes from zero to one. A pulse is an assert directly followed by a deassert. Level-triggered pins set remote IRR when they fire. An end-of-interrupt with a matching vector clears remote IRR, and it fires the pin again if the pin is still asserted. An entry write fires an unmasked pin that is still asserted and whose remote IRR is clear. Register decoding and the receiving controllers sit outside this block.

Top module: `irq_route_engine`

## Requirements
- R1: Each pin keeps a two's-complement count, reset to 0. An assert (`req_op`=1) adds one and a deassert (`req_op`=2) subtracts one. `cnt_neg[p]` is 1 exactly while pin p's count is below zero.
- R2: An assert fires the pin only when its count was 0 before the request. Other count changes, including -1 to 0 and 1 to 2, fire nothing.
- R3: A pulse (`req_op`=3) fires the pin if its count was 0, and it leaves the count unchanged. A pulse at count 1 fires nothing.
- R4: Entry bit 16 is the mask. A pin whose entry has bit 16 set is never made pending. After reset every entry is masked and all other fields are zero.
- R5: When a pin with entry bit 15 set (level trigger) fires, its `rirr` bit is set. Edge pins (bit 15 clear) never set `rirr`.
- R6: An end-of-interrupt with vector V acts on every pin whose `rirr` is set and whose entry bits 7:0 equal V, and all matching pins are compared in the same cycle. It clears `rirr` on each such pin. If the pin's count is still above zero and the pin is unmasked, the pin fires again.
- R7: An entry write fires the pin when the new entry is unmasked, `rirr` is clear and the count is above zero. Bit 14 of the written data is ignored.
- R8: The message fields come from the pin's entry. The vector is bits 7:0 and the delivery mode is bits 10:8. `dlv_phys` is the inverse of bit 11 (bit 11 set means logical). `dlv_level` is bit 15 and the destination is bits 63:56.
- R9: A request naming a pin number at or above the pin count is rejected. `req_err` is high for the one cycle after it, and no count changes.
- R10: Pending pins are sent one per handshake, lowest pin number first. A message that is offered is held unchanged until `dlv_ready` accepts it.
- R11: Events that fall in the same cycle are combined. If an end-of-interrupt re-fire and a pin request make two pins pending together, both messages are sent, lowest pin first. When one pin's `rirr` is both cleared and set again in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Pin request strobe |
| req_pin | input | 5 | Pin number of the request |
| req_op | input | 2 | 1 assert, 2 deassert, 3 pulse |
| req_err | output | 1 | Out-of-range request seen in the previous cycle |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | 8 | Vector being acknowledged |
| wr_valid | input | 1 | Entry write notification |
| wr_pin | input | 5 | Pin whose entry is written |
| wr_data | input | 64 | New routing entry |
| dlv_valid | output | 1 | Message offered |
| dlv_ready | input | 1 | Message accepted |
| dlv_vector | output | 8 | Message vector |
| dlv_dest | output | 8 | Message destination |
| dlv_phys | output | 1 | 1 physical, 0 logical destination |
| dlv_mode | output | 3 | Delivery mode |
| dlv_level | output | 1 | Level-trigger flag |
| rirr | output | 24 | Remote-IRR flag per pin |
| cnt_neg | output | 24 | Count-below-zero flag per pin |

## Verification
The functions that can land in the same cycle are the end-of-interrupt scan and a pin request on another pin. Both can make a pin pending on the same edge. The bench first gets a level pin waiting with remote IRR set and its count still 1. It then drives the matching end-of-interrupt and an assert of a higher edge pin on one clock edge. It judges the result by the order and contents of the two messages that follow, and by the level pin's remote IRR being set again. It also stacks three pending pins behind a held message to show lowest-first order and that the offered message holds steady.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef enum logic [1:0] {
    OP_NONE     = 2'd0,
    OP_ASSERT   = 2'd1,
    OP_DEASSERT = 2'd2,
    OP_PULSE    = 2'd3
  } irq_op_e;

  // Fields of a routing entry that this block consumes.
  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       level;
    logic       logical;
    logic [2:0] mode;
    logic [7:0] vec;
  } route_t;

  localparam route_t ROUTE_RESET = '{dest: 8'h00, mask: 1'b1, level: 1'b0,
                                     logical: 1'b0, mode: 3'd0, vec: 8'h00};

  function automatic route_t unpack_route(input logic [63:0] d);
    route_t r;
    r.vec     = d[7:0];
    r.mode    = d[10:8];
    r.logical = d[11];
    r.level   = d[15];
    r.mask    = d[16];
    r.dest    = d[63:56];
    return r;
  endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NPINS = 24,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic [NPINS-1:0] req,
  output logic             any,
  output logic [PIN_W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (req[i]) idx = PIN_W'(i);
    end
  end
endmodule

// File: rtl/irq_pin_slice.sv
module irq_pin_slice
  import irq_route_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int PIN_W = 5,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_ok,
  input  logic [PIN_W-1:0] req_pin,
  input  irq_op_e          req_op,
  input  logic             eoi_valid,
  input  logic [7:0]       eoi_vec,
  input  logic             wr_valid,
  input  logic [PIN_W-1:0] wr_pin,
  input  route_t           wr_route,
  input  logic             grant,
  output route_t           route_q,
  output logic             pend_q,
  output logic             rirr_q,
  output logic             neg
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  route_t route_n;
  logic req_hit, wr_hit, eoi_hit, rirr_mid;
  logic fire_req, fire_eoi, fire_wr, fire;
  logic cnt_pos;

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c,
                                                input irq_op_e op);
    case (op)
      OP_ASSERT:   return c + CNT_W'(1);
      OP_DEASSERT: return c - CNT_W'(1);
      default:     return c;
    endcase
  endfunction

  assign req_hit  = req_ok && (req_pin == PIN_W'(IDX));
  assign wr_hit   = wr_valid && (wr_pin == PIN_W'(IDX));
  assign cnt_n    = req_hit ? cnt_step(cnt_q, req_op) : cnt_q;
  assign cnt_pos  = !cnt_n[CNT_W-1] && (cnt_n != '0);
  assign route_n  = wr_hit ? wr_route : route_q;

  assign eoi_hit  = eoi_valid && rirr_q && (route_q.vec == eoi_vec);
  assign rirr_mid = rirr_q && !eoi_hit;

  assign fire_req = req_hit && (req_op == OP_ASSERT || req_op == OP_PULSE) &&
                    (cnt_q == '0);
  assign fire_eoi = eoi_hit && cnt_pos;
  assign fire_wr  = wr_hit && !rirr_mid && cnt_pos;
  assign fire     = (fire_req || fire_eoi || fire_wr) && !route_n.mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      route_q <= ROUTE_RESET;
      pend_q  <= 1'b0;
      rirr_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      route_q <= route_n;
      pend_q  <= (pend_q && !grant) || fire;
      rirr_q  <= rirr_mid || (fire && route_n.level);
    end
  end

  assign neg = cnt_q[CNT_W-1];

  // R1: an assert raises the count by exactly one
  a_r1_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    req_hit && req_op == OP_ASSERT |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R4: a pin only becomes pending under an unmasked entry
  a_r4_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> !route_q.mask);

  // R5: remote IRR is only raised together with a pending delivery
  a_r5_rirr_with_pend: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rirr_q) |-> pend_q && route_q.level);

  // R6: a matching end-of-interrupt with nothing asserted clears remote IRR
  a_r6_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_hit && !req_hit && !wr_hit && (cnt_q[CNT_W-1] || cnt_q == '0)
      |=> !rirr_q);
endmodule

// File: rtl/irq_dlv_stage.sv
module irq_dlv_stage
  import irq_route_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pend,
  input  route_t           routes [NPINS],
  output logic [NPINS-1:0] grant,
  output logic             out_valid,
  input  logic             out_ready,
  output route_t           out_route
);
  logic             any;
  logic [PIN_W-1:0] sel;
  logic             load;

  irq_prio_pick #(.NPINS(NPINS)) u_pick (.req(pend), .any(any), .idx(sel));

  assign load  = !out_valid || out_ready;
  assign grant = (load && any) ? (NPINS'(1) << sel) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_route <= ROUTE_RESET;
    end else if (load) begin
      out_valid <= any;
      if (any) out_route <= routes[sel];
    end
  end

  // R10: an offered message stays put until accepted
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_route));

  // R10: at most one pin is granted per cycle
  a_r10_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
  import irq_route_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int CNT_W = 8,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [PIN_W-1:0] req_pin,
  input  logic [1:0]       req_op,
  output logic             req_err,
  input  logic             eoi_valid,
  input  logic [7:0]       eoi_vec,
  input  logic             wr_valid,
  input  logic [PIN_W-1:0] wr_pin,
  input  logic [63:0]      wr_data,
  output logic             dlv_valid,
  input  logic             dlv_ready,
  output logic [7:0]       dlv_vector,
  output logic [7:0]       dlv_dest,
  output logic             dlv_phys,
  output logic [2:0]       dlv_mode,
  output logic             dlv_level,
  output logic [NPINS-1:0] rirr,
  output logic [NPINS-1:0] cnt_neg
);
  logic             req_ok, req_bad;
  route_t           wr_route;
  route_t           routes [NPINS];
  logic [NPINS-1:0] pend, grant;
  route_t           out_route;
  logic             unused_wr_bits;

  assign req_ok   = req_valid && (32'(req_pin) < NPINS);
  assign req_bad  = req_valid && !req_ok;
  assign wr_route = unpack_route(wr_data);
  assign unused_wr_bits = ^{wr_data[55:17], wr_data[14:12]};

  always_ff @(posedge clk) begin
    if (!rst_n) req_err <= 1'b0;
    else        req_err <= req_bad;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    irq_pin_slice #(.IDX(p), .PIN_W(PIN_W), .CNT_W(CNT_W)) u_slice (
      .clk(clk), .rst_n(rst_n),
      .req_ok(req_ok), .req_pin(req_pin), .req_op(irq_op_e'(req_op)),
      .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
      .wr_valid(wr_valid), .wr_pin(wr_pin), .wr_route(wr_route),
      .grant(grant[p]),
      .route_q(routes[p]), .pend_q(pend[p]), .rirr_q(rirr[p]),
      .neg(cnt_neg[p])
    );
  end

  irq_dlv_stage #(.NPINS(NPINS)) u_dlv (
    .clk(clk), .rst_n(rst_n), .pend(pend), .routes(routes), .grant(grant),
    .out_valid(dlv_valid), .out_ready(dlv_ready), .out_route(out_route)
  );

  assign dlv_vector = out_route.vec;
  assign dlv_dest   = out_route.dest;
  assign dlv_phys   = !out_route.logical;
  assign dlv_mode   = out_route.mode;
  assign dlv_level  = out_route.level;

  // R9: an out-of-range request is flagged in the next cycle
  a_r9_reject: assert property (@(posedge clk) disable iff (!rst_n)
    req_bad |=> req_err);
endmodule

// File: tb/irq_route_engine_test.sv
module irq_route_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [4:0]  req_pin = '0;
  logic [1:0]  req_op = '0;
  logic        req_err;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vec = '0;
  logic        wr_valid = 1'b0;
  logic [4:0]  wr_pin = '0;
  logic [63:0] wr_data = '0;
  logic        dlv_valid;
  logic        dlv_ready = 1'b0;
  logic [7:0]  dlv_vector, dlv_dest;
  logic        dlv_phys, dlv_level;
  logic [2:0]  dlv_mode;
  logic [23:0] rirr, cnt_neg;

  int n_run = 0;
  int n_fail = 0;

  irq_route_engine uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_pin(req_pin), .req_op(req_op), .req_err(req_err),
    .eoi_valid(eoi_valid), .eoi_vec(eoi_vec),
    .wr_valid(wr_valid), .wr_pin(wr_pin), .wr_data(wr_data),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
    .dlv_vector(dlv_vector), .dlv_dest(dlv_dest), .dlv_phys(dlv_phys),
    .dlv_mode(dlv_mode), .dlv_level(dlv_level),
    .rirr(rirr), .cnt_neg(cnt_neg)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_ent(input logic [7:0] vec, input logic [2:0] mode,
                                         input bit logical, input bit level,
                                         input bit mask, input logic [7:0] dest);
    logic [63:0] d = '0;
    d[7:0] = vec; d[10:8] = mode; d[11] = logical;
    d[15] = level; d[16] = mask; d[63:56] = dest;
    return d;
  endfunction

  task automatic do_req(input int pin, input int op);
    @(negedge clk);
    req_valid = 1'b1; req_pin = 5'(pin); req_op = 2'(op);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_eoi(input logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vec = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic do_wr(input int pin, input logic [63:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_pin = 5'(pin); wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic expect_msg(input string tag, input logic [7:0] vec, input logic [7:0] dest,
                            input bit phys, input logic [2:0] mode, input bit level);
    logic [20:0] act, exp;
    int waited = 0;
    while (!dlv_valid && waited < 10) begin
      @(negedge clk);
      waited++;
    end
    act = {dlv_vector, dlv_dest, dlv_phys, dlv_mode, dlv_level};
    exp = {vec, dest, phys, mode, level};
    chk(dlv_valid && act == exp, tag, longint'({dlv_valid, act}), longint'({1'b1, exp}));
    dlv_ready = 1'b1;
    @(negedge clk);
    dlv_ready = 1'b0;
  endtask

  task automatic expect_none(input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (dlv_valid) seen = 1'b1;
    end
    chk(!seen, tag, longint'(seen), 0);
    if (seen) begin
      dlv_ready = 1'b1;
      @(negedge clk);
      dlv_ready = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk(!dlv_valid && rirr == '0 && cnt_neg == '0 && !req_err, "R4 reset state",
        longint'({dlv_valid, rirr, cnt_neg, req_err}), 0);
    do_req(3, 1);
    expect_none("R4 reset entry is masked");
    do_req(3, 2);
  endtask

  task automatic t_edge_count;
    do_wr(2, mk_ent(8'h31, 3'd1, 1'b1, 1'b0, 1'b0, 8'h05));
    do_req(2, 1);
    expect_msg("R8 edge message fields", 8'h31, 8'h05, 1'b0, 3'd1, 1'b0);
    chk(rirr[2] == 1'b0, "R5 edge pin leaves rirr clear", longint'(rirr[2]), 0);
    do_req(2, 1);
    expect_none("R2 count 1 to 2 fires nothing");
    do_req(2, 2);
    do_req(2, 2);
    chk(cnt_neg[2] == 1'b0, "R1 count back at zero", longint'(cnt_neg[2]), 0);
    do_req(2, 2);
    chk(cnt_neg[2] == 1'b1, "R1 count below zero flagged", longint'(cnt_neg[2]), 1);
    do_req(2, 1);
    chk(cnt_neg[2] == 1'b0, "R1 count -1 to 0 clears flag", longint'(cnt_neg[2]), 0);
    expect_none("R2 count -1 to 0 fires nothing");
    do_req(2, 1);
    expect_msg("R2 count 0 to 1 fires", 8'h31, 8'h05, 1'b0, 3'd1, 1'b0);
    do_req(2, 2);
  endtask

  task automatic t_pulse;
    do_req(2, 3);
    expect_msg("R3 pulse at zero fires", 8'h31, 8'h05, 1'b0, 3'd1, 1'b0);
    do_req(2, 1);
    expect_msg("R3 pulse left count at zero", 8'h31, 8'h05, 1'b0, 3'd1, 1'b0);
    do_req(2, 3);
    expect_none("R3 pulse at one fires nothing");
    do_req(2, 2);
    chk(cnt_neg[2] == 1'b0, "R3 count back at zero", longint'(cnt_neg[2]), 0);
  endtask

  task automatic t_level_eoi;
    do_wr(5, mk_ent(8'h40, 3'd3, 1'b0, 1'b1, 1'b0, 8'hA0));
    do_req(5, 1);
    expect_msg("R8 level message fields", 8'h40, 8'hA0, 1'b1, 3'd3, 1'b1);
    chk(rirr[5] == 1'b1, "R5 level fire sets rirr", longint'(rirr[5]), 1);
    do_eoi(8'h41);
    expect_none("R6 other vector ignored");
    chk(rirr[5] == 1'b1, "R6 other vector keeps rirr", longint'(rirr[5]), 1);
    do_eoi(8'h40);
    expect_msg("R6 eoi re-fires asserted pin", 8'h40, 8'hA0, 1'b1, 3'd3, 1'b1);
    chk(rirr[5] == 1'b1, "R6 re-fire sets rirr again", longint'(rirr[5]), 1);
    do_req(5, 2);
    do_eoi(8'h40);
    expect_none("R6 eoi with count zero fires nothing");
    chk(rirr[5] == 1'b0, "R6 eoi clears rirr", longint'(rirr[5]), 0);
  endtask

  task automatic t_entry_write;
    logic [63:0] e;
    do_wr(7, mk_ent(8'h70, 3'd0, 1'b0, 1'b1, 1'b1, 8'h33));
    do_req(7, 1);
    expect_none("R4 masked level pin holds");
    e = mk_ent(8'h70, 3'd0, 1'b0, 1'b1, 1'b0, 8'h33);
    e[14] = 1'b1;
    do_wr(7, e);
    expect_msg("R7 unmask write fires", 8'h70, 8'h33, 1'b1, 3'd0, 1'b1);
    chk(rirr[7] == 1'b1, "R7 write fire sets rirr", longint'(rirr[7]), 1);
    do_wr(7, e);
    expect_none("R7 write with rirr set fires nothing");
    do_req(7, 2);
    do_eoi(8'h70);
    chk(rirr[7] == 1'b0, "R7 rirr cleared for cleanup", longint'(rirr[7]), 0);
  endtask

  task automatic t_bad_pin;
    @(negedge clk);
    req_valid = 1'b1; req_pin = 5'd24; req_op = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_err == 1'b1, "R9 pin 24 rejected", longint'(req_err), 1);
    @(negedge clk);
    chk(req_err == 1'b0, "R9 error lasts one cycle", longint'(req_err), 0);
    chk(cnt_neg == '0, "R9 no count touched", longint'(cnt_neg), 0);
    do_req(31, 1);
    expect_none("R9 pin 31 fires nothing");
  endtask

  task automatic t_priority;
    do_wr(11, mk_ent(8'hB1, 3'd0, 1'b0, 1'b0, 1'b0, 8'h11));
    do_wr(9,  mk_ent(8'h91, 3'd0, 1'b0, 1'b0, 1'b0, 8'h09));
    do_wr(4,  mk_ent(8'h41, 3'd2, 1'b0, 1'b0, 1'b0, 8'h04));
    do_req(11, 1);
    do_req(9, 1);
    do_req(4, 1);
    repeat (3) @(negedge clk);
    chk(dlv_valid && dlv_vector == 8'hB1, "R10 held message unchanged",
        longint'({dlv_valid, dlv_vector}), longint'({1'b1, 8'hB1}));
    expect_msg("R10 first held pin 11", 8'hB1, 8'h11, 1'b1, 3'd0, 1'b0);
    expect_msg("R10 lowest pending pin 4 next", 8'h41, 8'h04, 1'b1, 3'd2, 1'b0);
    expect_msg("R10 then pin 9", 8'h91, 8'h09, 1'b1, 3'd0, 1'b0);
    do_req(11, 2);
    do_req(9, 2);
    do_req(4, 2);
  endtask

  task automatic t_same_cycle;
    do_wr(12, mk_ent(8'h52, 3'd0, 1'b0, 1'b0, 1'b0, 8'h12));
    do_req(5, 1);
    expect_msg("R11 level pin 5 first fire", 8'h40, 8'hA0, 1'b1, 3'd3, 1'b1);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vec = 8'h40;
    req_valid = 1'b1; req_pin = 5'd12; req_op = 2'd1;
    @(negedge clk);
    eoi_valid = 1'b0; req_valid = 1'b0;
    expect_msg("R11 eoi re-fire pin 5 first", 8'h40, 8'hA0, 1'b1, 3'd3, 1'b1);
    expect_msg("R11 assert pin 12 second", 8'h52, 8'h12, 1'b1, 3'd0, 1'b0);
    chk(rirr[5] == 1'b1, "R11 set wins over clear", longint'(rirr[5]), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_edge_count();
    t_pulse();
    t_level_eoi();
    t_entry_write();
    t_bad_pin();
    t_priority();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule